// File: doc/BRIEF.md
# Round-Robin Interrupt Thread Selector

This block picks, in each cycle, at most one hardware thread that is allowed to take its pending interrupt. Each thread supplies three flags: an interrupt is pending, the thread is not draining, and the thread is currently between whole instructions. A thread whose interrupt is pending and that is not draining counts as interrupted. It is served only when it is also between instructions, so an interrupt never splits an instruction.

Candidates are scanned in round-robin order. The scan starts at a stored pointer and wraps at the thread count. The first thread that qualifies wins. The pointer then moves to that served thread and stays where it is in cycles where nothing is served. Selection is combinational from the inputs and the pointer. The pointer is registered.

When a thread is served, the block drops the issue and commit enables for every thread for that cycle, and it passes the served thread's program counter out as the redirect target. When no thread is served, any interrupted thread is limited to committing micro-ops, so that it can reach an instruction boundary. The aggregate interrupted flag reports whether any thread is interrupted, whether or not one was served.

Top module: `irq_thread_sel`

## Requirements
- R1: A thread is interrupted exactly when its irq_pending bit is 1 and its not_draining bit is 1. any_irq is 1 exactly when at least one thread is interrupted, whether or not a thread is served.
- R2: A thread can be served only when it is interrupted and its between_insts bit is 1. Otherwise it is never selected.
- R3: The scan visits thread indices ptr, ptr+1, ... modulo NTHREADS. take_tid is the first qualifying index in that order.
- R4: On each rising clock edge with take_valid = 1, the pointer becomes take_tid. With take_valid = 0 the pointer keeps its value.
- R5: When no thread qualifies, take_valid is 0, take_tid is 0 and take_pc is 0.
- R6: While take_valid is 1, take_pc equals the PC_W-bit slice thread_pc[take_tid*PC_W +: PC_W].
- R7: issue_en and commit_en are both 0 in a cycle with take_valid = 1, and both are 1 otherwise.
- R8: When take_valid is 0, uop_only[i] equals the interrupted flag of thread i. When take_valid is 1, uop_only is all zero.
- R9: A synchronous reset (rst_n low at a rising edge) sets the pointer to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pending | input | NTHREADS | Per-thread interrupt pending |
| not_draining | input | NTHREADS | Per-thread not-draining flag |
| between_insts | input | NTHREADS | Per-thread flag, set when the thread is at a whole-instruction boundary |
| thread_pc | input | NTHREADS*PC_W | Per-thread current PC; thread i occupies bits [i*PC_W +: PC_W] |
| take_valid | output | 1 | A thread takes its interrupt this cycle |
| take_tid | output | TID_W | Served thread index |
| take_pc | output | PC_W | Redirect target (PC of served thread) |
| any_irq | output | 1 | At least one thread is interrupted |
| issue_en | output | 1 | Issue is allowed this cycle |
| commit_en | output | 1 | Commit is allowed this cycle |
| uop_only | output | NTHREADS | Per-thread restriction to micro-op commit |

## Verification
The bench builds the block with NTHREADS = 3 and PC_W = 16. A thread count that is not a power of two exercises the wrap of the scan at a boundary that a plain bit truncation would get wrong. Directed cycles place the only candidate behind the pointer, so the scan must wrap. They also hold several candidates at once, which shows that the pointer parks on the served thread, and they mix draining and mid-instruction threads. Pseudo-random cycles then compare every output against a behavioural model on each clock.

// File: rtl/irq_sel_pkg.sv
// Package: shared helpers for the interrupt thread selector.
// Assumes indices are non-negative and below twice the thread count.
package irq_sel_pkg;
    // Wrap a scan index back into the range 0 .. n-1.
    function automatic int rr_wrap(input int idx, input int n);
        return (idx >= n) ? idx - n : idx;
    endfunction
endpackage

// File: rtl/irq_qualify.sv
// Module: irq_qualify
// Computes, for each thread, the interrupted flag (pending and not draining)
// and the eligible flag (interrupted and between whole instructions).
// Assumes all inputs are stable for the cycle, since the module is purely combinational.
module irq_qualify #(
    parameter int NTHREADS = 4
) (
    input  logic [NTHREADS-1:0] irq_pending,
    input  logic [NTHREADS-1:0] not_draining,
    input  logic [NTHREADS-1:0] between_insts,
    output logic [NTHREADS-1:0] interrupted,
    output logic [NTHREADS-1:0] eligible
);
    for (genvar g = 0; g < NTHREADS; g++) begin : g_thr
        // Per-thread qualification of the interrupt request.
        always_comb begin
            interrupted[g] = irq_pending[g] & not_draining[g];
            eligible[g]    = interrupted[g] & between_insts[g];
        end
    end
endmodule

// File: rtl/irq_rr_scan.sv
// Module: irq_rr_scan
// Round-robin scan over the eligible vector, starting at ptr and wrapping at NTHREADS.
// Returns the first eligible index. Assumes ptr < NTHREADS.
module irq_rr_scan
    import irq_sel_pkg::*;
#(
    parameter int NTHREADS = 4,
    parameter int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic [NTHREADS-1:0] eligible,
    input  logic [TID_W-1:0]    ptr,
    output logic                found,
    output logic [TID_W-1:0]    tid
);
    // Walk the threads from the pointer and keep the first hit.
    always_comb begin
        found = 1'b0;
        tid   = '0;
        for (int k = 0; k < NTHREADS; k++) begin
            int idx;
            idx = rr_wrap(int'(ptr) + k, NTHREADS);
            if (!found && eligible[idx]) begin
                found = 1'b1;
                tid   = TID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/irq_ptr_reg.sv
// Module: irq_ptr_reg
// Holds the round-robin priority pointer. It loads the served thread and otherwise keeps its value.
// Synchronous active-low reset to thread 0.
module irq_ptr_reg #(
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TID_W-1:0] next_tid,
    output logic [TID_W-1:0] ptr
);
    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= next_tid;
    end

    AST_PTR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(next_tid))); // R4
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ptr)); // R4
endmodule

// File: rtl/irq_thread_sel.sv
// Module: irq_thread_sel (top)
// Chooses, each cycle, at most one thread to take its interrupt. Candidates are scanned
// round-robin from a stored pointer. Only threads that are interrupted and between
// instructions qualify. Issue and commit are suppressed while a thread is served.
// Assumes thread_pc packs thread i at bits [i*PC_W +: PC_W].
module irq_thread_sel #(
    parameter int NTHREADS = 4,
    parameter int PC_W     = 32,
    parameter int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTHREADS-1:0]      irq_pending,
    input  logic [NTHREADS-1:0]      not_draining,
    input  logic [NTHREADS-1:0]      between_insts,
    input  logic [NTHREADS*PC_W-1:0] thread_pc,
    output logic                     take_valid,
    output logic [TID_W-1:0]         take_tid,
    output logic [PC_W-1:0]          take_pc,
    output logic                     any_irq,
    output logic                     issue_en,
    output logic                     commit_en,
    output logic [NTHREADS-1:0]      uop_only
);
    logic [NTHREADS-1:0] interrupted;
    logic [NTHREADS-1:0] eligible;
    logic [TID_W-1:0]    ptr;
    logic                found;
    logic [TID_W-1:0]    scan_tid;

    irq_qualify #(.NTHREADS(NTHREADS)) u_qual (
        .irq_pending   (irq_pending),
        .not_draining  (not_draining),
        .between_insts (between_insts),
        .interrupted   (interrupted),
        .eligible      (eligible)
    );

    irq_rr_scan #(.NTHREADS(NTHREADS), .TID_W(TID_W)) u_scan (
        .eligible (eligible),
        .ptr      (ptr),
        .found    (found),
        .tid      (scan_tid)
    );

    irq_ptr_reg #(.TID_W(TID_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (found),
        .next_tid (scan_tid),
        .ptr      (ptr)
    );

    // Output stage: the selection, its redirect target, and the pipeline gating.
    always_comb begin
        take_valid = found;
        take_tid   = found ? scan_tid : '0;
        take_pc    = found ? thread_pc[int'(scan_tid)*PC_W +: PC_W] : '0;
        any_irq    = |interrupted;
        issue_en   = !found;
        commit_en  = !found;
        uop_only   = found ? '0 : interrupted;
    end

    AST_SEL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (irq_pending[take_tid] && not_draining[take_tid] && between_insts[take_tid])); // R2
    AST_SEL_IMPLIES_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> any_irq); // R1
    AST_NO_ISSUE_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (!issue_en && !commit_en)); // R7
    AST_UOP_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (uop_only == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_valid |-> (take_tid == '0 && take_pc == '0)); // R5
endmodule

// File: tb/irq_thread_sel_tb.sv
module irq_thread_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT   = 3;
    localparam int PCW  = 16;
    localparam int TIDW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT-1:0]   irq_pending = '0;
    logic [NT-1:0]   not_draining = '0;
    logic [NT-1:0]   between_insts = '0;
    logic [NT*PCW-1:0] thread_pc = '0;
    logic            take_valid;
    logic [TIDW-1:0] take_tid;
    logic [PCW-1:0]  take_pc;
    logic            any_irq;
    logic            issue_en;
    logic            commit_en;
    logic [NT-1:0]   uop_only;

    int checks = 0;
    int errors = 0;
    int mptr = 0;

    irq_thread_sel #(.NTHREADS(NT), .PC_W(PCW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .not_draining(not_draining),
        .between_insts(between_insts), .thread_pc(thread_pc), .take_valid(take_valid),
        .take_tid(take_tid), .take_pc(take_pc), .any_irq(any_irq), .issue_en(issue_en),
        .commit_en(commit_en), .uop_only(uop_only)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, compare with the model, then advance the model pointer.
    task automatic step(input logic [NT-1:0] p, input logic [NT-1:0] nd, input logic [NT-1:0] b);
        int  e_tid, e_pc, e_intr, e_elig;
        bit  e_val;
        @(negedge clk);
        irq_pending = p; not_draining = nd; between_insts = b;
        for (int i = 0; i < NT; i++) thread_pc[i*PCW +: PCW] = PCW'($urandom);
        #1;
        e_intr = 0; e_elig = 0;
        for (int i = 0; i < NT; i++) begin
            if (p[i] && nd[i]) e_intr |= (1 << i);
            if (p[i] && nd[i] && b[i]) e_elig |= (1 << i);
        end
        e_val = 0; e_tid = 0;
        for (int k = 0; k < NT; k++) begin
            int idx = (mptr + k) % NT;
            if (!e_val && e_elig[idx]) begin e_val = 1; e_tid = idx; end
        end
        e_pc = e_val ? int'(thread_pc[e_tid*PCW +: PCW]) : 0;
        chk("R1", "any_irq", int'(any_irq), int'(e_intr != 0));
        chk("R3", "take_valid", int'(take_valid), int'(e_val));
        chk("R3", "take_tid", int'(take_tid), e_tid);
        chk("R6", "take_pc", int'(take_pc), e_pc);
        chk("R7", "issue_en", int'(issue_en), int'(!e_val));
        chk("R7", "commit_en", int'(commit_en), int'(!e_val));
        chk("R8", "uop_only", int'(uop_only), e_val ? 0 : e_intr);
        @(posedge clk);
        if (e_val) mptr = e_tid; // R4
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        mptr = 0;
        // R9: after reset the pointer is 0, so with all eligible thread 0 wins
        step(3'b111, 3'b111, 3'b111);
        // R4: the pointer parks on the served thread, so thread 0 wins again
        step(3'b111, 3'b111, 3'b111);
        // R5: nothing pending
        step(3'b000, 3'b111, 3'b111);
        chk("R5", "idle valid", int'(take_valid), 0);
        // R1: pending but draining is not interrupted
        step(3'b111, 3'b000, 3'b111);
        // R2: interrupted but mid-instruction is not served; R8 micro-op restriction
        step(3'b110, 3'b111, 3'b001);
        // R3: only thread 2 eligible, pointer moves to 2
        step(3'b100, 3'b111, 3'b111);
        // R3: threads 0 and 1 eligible, scan from 2 wraps to 0
        step(3'b011, 3'b111, 3'b111);
        // R3: threads 1 and 2 eligible from pointer 0 gives 1
        step(3'b110, 3'b111, 3'b111);
        // R4: nothing served holds the pointer at 1; then 0 and 2 eligible gives 2
        step(3'b000, 3'b000, 3'b000);
        step(3'b101, 3'b111, 3'b111);
        // R9: reset mid-run returns the pointer to 0
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        mptr = 0;
        step(3'b110, 3'b111, 3'b111);
        // Random mix for R1 through R8
        for (int n = 0; n < 400; n++)
            step(NT'($urandom), NT'($urandom | $urandom), NT'($urandom | $urandom));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule